// File: doc/BRIEF.md
# Dynamic Bus Width Adapter

This block connects a 32-bit host bus to a peripheral port whose width is 32, 16 or 8 bits, chosen per access. The host gives a chip select, a byte offset, a transfer size code and a read/write flag. The block splits the request into as many narrower peripheral cycles as it needs. It moves each byte to the lane where the port expects it. On reads it builds the returned bytes into one 32-bit word. It ends the whole access with a single transfer acknowledge.

A fixed run of internal phases follows each accepted request. The host control, port width and write data are captured at the end of the fourth phase, so the host may release its bus before the peripheral side has finished. Dropping the chip select part-way through an access abandons it. No acknowledge is then given and nothing moved so far is kept, so a retry must repeat the whole access.

Top module: `bus_sizer`

## Requirements
- R1: While reset is low, host_ack, host_rdata, periph_strobe and periph_wr are all zero.
- R2: An access starts only on a rising edge where host_cs is high and the edge before saw host_cs low. Keeping host_cs high after an acknowledge starts no further peripheral cycle.
- R3: host_addr, host_size, host_wr, port_width and host_wdata are sampled once, on the fifth rising edge counted from and including the start edge. Later changes to them have no effect on that access.
- R4: port_width code 00 selects a 32-bit port, 01 a 16-bit port and 10 an 8-bit port. host_size code 01 means 1 byte, 10 means 2, 11 means 3 and 00 means 4. Each peripheral cycle moves min(remaining bytes, port bytes - (offset mod port bytes)) bytes, so a 4-byte access takes four cycles on an 8-bit port and two on a 16-bit port.
- R5: periph_addr equals host_addr in the first peripheral cycle and then advances by the byte count of each finished cycle. periph_size gives that count in the host_size encoding.
- R6: Byte offset k travels on big-endian lane k, that is bits 31-8k down to 24-8k. An 8-bit port uses lane 0 and a 16-bit port uses lanes 0-1. On writes, the port's lanes are copied into every remaining lane of periph_wdata.
- R7: At the acknowledge of a read, host_rdata holds each requested byte on its own lane, and lanes outside the request are zero. Lanes of periph_rdata outside the port width are ignored. At the acknowledge of a write, host_rdata is zero.
- R8: host_ack is high for exactly one cycle, beginning two rising edges after the edge that takes the last peripheral ready.
- R9: host_rdata is zero whenever host_ack is low.
- R10: host_cs sampled low during an access returns the block to idle. No acknowledge follows, periph_strobe is low in the next cycle, and the next access returns only its own data.
- R11: A peripheral cycle keeps periph_strobe, periph_addr, periph_size and periph_wdata steady until periph_ready is sampled high.
- R12: periph_wr is high only while periph_strobe is high during a write access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host chip select, active high |
| host_addr | input | 2 | Byte offset of the access in the 32-bit word |
| host_size | input | 2 | Transfer size code |
| host_wr | input | 1 | 1 for write, 0 for read |
| port_width | input | 2 | Width code of the peripheral for this access |
| host_wdata | input | 32 | Host write data, big-endian lanes |
| host_rdata | output | 32 | Assembled read word, valid with host_ack |
| host_ack | output | 1 | Single-cycle end-of-access acknowledge |
| periph_strobe | output | 1 | A peripheral cycle is in progress |
| periph_wr | output | 1 | The current peripheral cycle is a write |
| periph_addr | output | 2 | Byte offset of the current peripheral cycle |
| periph_size | output | 2 | Bytes moved by the current cycle, size encoding |
| periph_wdata | output | 32 | Steered write data |
| periph_rdata | input | 32 | Peripheral read data |
| periph_ready | input | 1 | Peripheral completes the current cycle |

## Verification
The properties assume that periph_ready is raised only while periph_strobe is high. They also assume that no request runs past the end of the 32-bit word, meaning the offset plus the size never exceeds four bytes. The stimulus keeps to both. The peripheral model answers only to a strobe, after a set number of wait cycles, and every table entry and directed case uses an offset and size that fit in the word. After the capture edge the bench deliberately scrambles the host inputs, including into the reserved width code, since by then the block must no longer look at them.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SYNC1 = 3'd1,
      ST_SYNC2 = 3'd2,
      ST_SYNC3 = 3'd3,
      ST_LATCH = 3'd4,
      ST_XFER  = 3'd5,
      ST_DONE  = 3'd6,
      ST_ACK   = 3'd7
   } bsz_state_t;

   typedef enum logic [1:0] {
      PW_FULL = 2'b00,
      PW_HALF = 2'b01,
      PW_BYTE = 2'b10,
      PW_RSVD = 2'b11
   } bsz_width_t;

endpackage

// File: rtl/bsz_plan.sv
// Per-cycle planner: how many bytes the current peripheral cycle moves.
module bsz_plan #(
   parameter int unsigned LANES = 4,
   localparam int unsigned OFF_W = $clog2(LANES),
   localparam int unsigned CNT_W = OFF_W + 1
) (
   input  logic [1:0]       width,
   input  logic [OFF_W-1:0] off,
   input  logic [CNT_W-1:0] rem,
   output logic [CNT_W-1:0] cnt,
   output logic [OFF_W-1:0] pmask
);
   import bsz_pkg::*;

   logic [CNT_W-1:0] plane;
   logic [CNT_W-1:0] room;

   always_comb begin
      case (bsz_width_t'(width))
         PW_HALF: plane = CNT_W'(LANES / 2);
         PW_BYTE: plane = CNT_W'(1);
         default: plane = CNT_W'(LANES);
      endcase
      pmask = plane[OFF_W-1:0] - OFF_W'(1);
      room  = plane - {1'b0, off & pmask};
      cnt   = (rem < room) ? rem : room;
   end

endmodule

// File: rtl/bsz_seq.sv
// Phase sequencer: start gating, capture phase, transfer, acknowledge, abort.
module bsz_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic ready,
   input  logic last,
   output logic latch_en,
   output logic step,
   output logic strobe,
   output logic ack
);
   import bsz_pkg::*;

   bsz_state_t state_q, state_d;
   logic       armed_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (cs && armed_q) state_d = ST_SYNC1;
         ST_SYNC1: state_d = cs ? ST_SYNC2 : ST_IDLE;
         ST_SYNC2: state_d = cs ? ST_SYNC3 : ST_IDLE;
         ST_SYNC3: state_d = cs ? ST_LATCH : ST_IDLE;
         ST_LATCH: state_d = cs ? ST_XFER  : ST_IDLE;
         ST_XFER: begin
            if (!cs)                state_d = ST_IDLE;
            else if (ready && last) state_d = ST_DONE;
         end
         ST_DONE:  state_d = cs ? ST_ACK : ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         armed_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (!cs)
            armed_q <= 1'b1;
         else if (state_q == ST_IDLE && armed_q)
            armed_q <= 1'b0;
      end
   end

   assign latch_en = (state_q == ST_LATCH) && cs;
   assign strobe   = (state_q == ST_XFER);
   assign step     = strobe && cs && ready;
   assign ack      = (state_q == ST_ACK);

endmodule

// File: rtl/bsz_lanes.sv
// Byte-lane datapath: write capture and steering, read merge and hold.
module bsz_lanes #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned LANES = DATA_W / LANE_W,
   localparam int unsigned OFF_W = $clog2(LANES),
   localparam int unsigned CNT_W = OFF_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch_en,
   input  logic              step,
   input  logic              rd_en,
   input  logic              ack,
   input  logic [OFF_W-1:0]  off,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [OFF_W-1:0]  pmask,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] periph_rdata,
   output logic [DATA_W-1:0] periph_wdata,
   output logic [DATA_W-1:0] host_rdata
);

   logic [DATA_W-1:0] wd_q;
   logic [LANE_W-1:0] wd_lane [LANES];
   logic [LANE_W-1:0] rd_lane [LANES];

   always_ff @(posedge clk) begin
      if (!rst_n)
         wd_q <= '0;
      else if (latch_en)
         wd_q <= host_wdata;
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int unsigned HI = DATA_W - 1 - LANE_W * k;
      logic [OFF_W-1:0]  wsrc;
      logic [OFF_W-1:0]  rsrc;
      logic              take;
      logic [LANE_W-1:0] hold_q;

      assign wd_lane[k] = wd_q[HI -: LANE_W];
      assign rd_lane[k] = periph_rdata[HI -: LANE_W];

      // aligned base of the port window plus this lane's position inside it
      assign wsrc = (off & ~pmask) | (OFF_W'(k) & pmask);
      assign periph_wdata[HI -: LANE_W] = wd_lane[wsrc];

      assign rsrc = OFF_W'(k) & pmask;
      assign take = (CNT_W'(k) >= {1'b0, off}) && (CNT_W'(k) < ({1'b0, off} + cnt));

      always_ff @(posedge clk) begin
         if (!rst_n)
            hold_q <= '0;
         else if (latch_en)
            hold_q <= '0;
         else if (step && rd_en && take)
            hold_q <= rd_lane[rsrc];
      end

      assign host_rdata[HI -: LANE_W] = ack ? hold_q : '0;
   end

endmodule

// File: rtl/bus_sizer.sv
module bus_sizer #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned LANES = DATA_W / LANE_W,
   localparam int unsigned OFF_W = $clog2(LANES),
   localparam int unsigned CNT_W = OFF_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs,
   input  logic [OFF_W-1:0]  host_addr,
   input  logic [OFF_W-1:0]  host_size,
   input  logic              host_wr,
   input  logic [1:0]        port_width,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_ack,
   output logic              periph_strobe,
   output logic              periph_wr,
   output logic [OFF_W-1:0]  periph_addr,
   output logic [OFF_W-1:0]  periph_size,
   output logic [DATA_W-1:0] periph_wdata,
   input  logic [DATA_W-1:0] periph_rdata,
   input  logic              periph_ready
);

   if (DATA_W % LANE_W != 0) begin : g_bad_split
      $error("DATA_W must be a whole number of lanes");
   end
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("lane count must be a power of two of at least 2");
   end

   logic              latch_en, step, strobe, ack, last;
   logic [OFF_W-1:0]  off_q;
   logic [CNT_W-1:0]  rem_q;
   logic [1:0]        width_q;
   logic              wr_q;
   logic [CNT_W-1:0]  cnt;
   logic [OFF_W-1:0]  pmask;
   logic [CNT_W-1:0]  req_bytes;

   assign req_bytes = (host_size == '0) ? CNT_W'(LANES) : {1'b0, host_size};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q   <= '0;
         rem_q   <= '0;
         width_q <= '0;
         wr_q    <= 1'b0;
      end else if (latch_en) begin
         off_q   <= host_addr;
         rem_q   <= req_bytes;
         width_q <= port_width;
         wr_q    <= host_wr;
      end else if (step) begin
         off_q   <= off_q + cnt[OFF_W-1:0];
         rem_q   <= rem_q - cnt;
      end
   end

   assign last = (cnt == rem_q);

   bsz_plan #(.LANES(LANES)) i_plan (
      .width (width_q),
      .off   (off_q),
      .rem   (rem_q),
      .cnt   (cnt),
      .pmask (pmask)
   );

   bsz_seq i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs       (host_cs),
      .ready    (periph_ready),
      .last     (last),
      .latch_en (latch_en),
      .step     (step),
      .strobe   (strobe),
      .ack      (ack)
   );

   bsz_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_lanes (
      .clk          (clk),
      .rst_n        (rst_n),
      .latch_en     (latch_en),
      .step         (step),
      .rd_en        (!wr_q),
      .ack          (ack),
      .off          (off_q),
      .cnt          (cnt),
      .pmask        (pmask),
      .host_wdata   (host_wdata),
      .periph_rdata (periph_rdata),
      .periph_wdata (periph_wdata),
      .host_rdata   (host_rdata)
   );

   assign host_ack      = ack;
   assign periph_strobe = strobe;
   assign periph_wr     = strobe && wr_q;
   assign periph_addr   = off_q;
   assign periph_size   = cnt[OFF_W-1:0];

endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned LANES = DATA_W / LANE_W,
   localparam int unsigned OFF_W = $clog2(LANES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_cs,
   input logic [OFF_W-1:0]  host_addr,
   input logic [OFF_W-1:0]  host_size,
   input logic              host_wr,
   input logic [1:0]        port_width,
   input logic [DATA_W-1:0] host_wdata,
   input logic [DATA_W-1:0] host_rdata,
   input logic              host_ack,
   input logic              periph_strobe,
   input logic              periph_wr,
   input logic [OFF_W-1:0]  periph_addr,
   input logic [OFF_W-1:0]  periph_size,
   input logic [DATA_W-1:0] periph_wdata,
   input logic [DATA_W-1:0] periph_rdata,
   input logic              periph_ready
);

   // R8: the acknowledge never lasts two cycles
   assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |=> !host_ack);

   // R8: an acknowledge follows a taken ready by exactly two edges
   assert_ack_after_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_ack) |-> (!$past(periph_strobe) && $past(periph_strobe, 2) && $past(periph_ready, 2)));

   // R10: a low chip select cancels any pending acknowledge
   assert_abort_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !host_cs |=> !host_ack);

   // R2: no peripheral cycle runs in the cycle after chip select is seen low
   assert_no_strobe_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !host_cs |=> !periph_strobe);

   // R11: a waiting peripheral cycle keeps its address, size and data
   assert_cycle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_strobe && !periph_ready && host_cs) |=>
         (periph_strobe && $stable(periph_addr) && $stable(periph_size) && $stable(periph_wdata)));

   // R12: direction stays fixed across back-to-back peripheral cycles
   assert_dir_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_strobe && $past(periph_strobe)) |-> $stable(periph_wr));

endmodule

bind bus_sizer bus_sizer_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_chk (.*);

// File: tb/test_bus_sizer.sv
`timescale 1ns/1ps
module test_bus_sizer;

   typedef struct packed {
      logic        wr;
      logic [1:0]  size;
      logic [1:0]  addr;
      logic [1:0]  width;
      logic [1:0]  waitn;
      logic [2:0]  ncyc;
      logic [31:0] wdata;
      logic [31:0] pinit;
   } vec_t;

   // size: 00=4 01=1 10=2 11=3 bytes ; width: 00=32 01=16 10=8
   localparam vec_t VEC [14] = '{
      '{1'b0, 2'b00, 2'd0, 2'b00, 2'd0, 3'd1, 32'h0, 32'hA1B2C3D4},
      '{1'b0, 2'b00, 2'd0, 2'b01, 2'd1, 3'd2, 32'h0, 32'h0F1E2D3C},
      '{1'b0, 2'b00, 2'd0, 2'b10, 2'd0, 3'd4, 32'h0, 32'h11223344},
      '{1'b0, 2'b10, 2'd2, 2'b01, 2'd2, 3'd1, 32'h0, 32'h55667788},
      '{1'b0, 2'b10, 2'd1, 2'b01, 2'd0, 3'd2, 32'h0, 32'h99AABBCC},
      '{1'b0, 2'b01, 2'd3, 2'b10, 2'd1, 3'd1, 32'h0, 32'hDEADBEEF},
      '{1'b0, 2'b11, 2'd1, 2'b10, 2'd0, 3'd3, 32'h0, 32'h01020304},
      '{1'b0, 2'b11, 2'd1, 2'b01, 2'd0, 3'd2, 32'h0, 32'hCAFEF00D},
      '{1'b1, 2'b00, 2'd0, 2'b10, 2'd0, 3'd4, 32'h12345678, 32'h00000000},
      '{1'b1, 2'b10, 2'd2, 2'b01, 2'd1, 3'd1, 32'h0000ABCD, 32'hFFFFFFFF},
      '{1'b1, 2'b11, 2'd0, 2'b01, 2'd0, 3'd2, 32'hA5B6C7D8, 32'h00000000},
      '{1'b1, 2'b00, 2'd0, 2'b00, 2'd3, 3'd1, 32'h87654321, 32'h00000000},
      '{1'b1, 2'b01, 2'd1, 2'b01, 2'd0, 3'd1, 32'h00EE0000, 32'h11111111},
      '{1'b0, 2'b10, 2'd1, 2'b00, 2'd0, 3'd1, 32'h0, 32'h10203040}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        host_cs;
   logic [1:0]  host_addr, host_size, port_width;
   logic        host_wr;
   logic [31:0] host_wdata, host_rdata;
   logic        host_ack, periph_strobe, periph_wr;
   logic [1:0]  periph_addr, periph_size;
   logic [31:0] periph_wdata, periph_rdata;
   logic        periph_ready;

   always #2.5 clk = ~clk;

   bus_sizer i_bus_sizer (
      .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_addr(host_addr),
      .host_size(host_size), .host_wr(host_wr), .port_width(port_width),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
      .periph_strobe(periph_strobe), .periph_wr(periph_wr),
      .periph_addr(periph_addr), .periph_size(periph_size),
      .periph_wdata(periph_wdata), .periph_rdata(periph_rdata),
      .periph_ready(periph_ready)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
         $finish;
      end
   end

   // peripheral model state, touched only by the main process
   logic [7:0] pmem [4];
   int  negcnt = 0, proc_cnt = 0, last_proc = 0, wcnt = 0, wait_n = 0;
   logic [1:0] cur_width, exp_next, wait_addr;
   logic       cur_wr;
   bit  seq_ok, repl_ok, wr_ok;

   function automatic logic [7:0] lane(input logic [31:0] v, input int k);
      return v[31 - 8*k -: 8];
   endfunction

   function automatic int lanes_of(input logic [1:0] w);
      return (w == 2'b01) ? 2 : (w == 2'b10) ? 1 : 4;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_step();
      int n, p, base;
      if (periph_ready) begin
         periph_ready = 1'b0;
         wcnt = 0;
         periph_rdata = 32'hEEEEEEEE;
      end else if (periph_strobe) begin
         if (wcnt == 0) wait_addr = periph_addr;
         else if (periph_addr != wait_addr) seq_ok = 0;
         if (wcnt >= wait_n) begin
            n = (periph_size == 2'd0) ? 4 : int'(periph_size);
            p = lanes_of(cur_width);
            base = int'(periph_addr) & ~(p - 1);
            if (periph_addr != exp_next) seq_ok = 0;
            exp_next = exp_next + 2'(n);
            if (periph_wr != cur_wr) wr_ok = 0;
            if (periph_wr) begin
               for (int i = 0; i < n; i++)
                  pmem[(int'(periph_addr) + i) % 4] = lane(periph_wdata, (int'(periph_addr) + i) % p);
               for (int l = 0; l < 4; l++)
                  if (lane(periph_wdata, l) != lane(periph_wdata, l % p)) repl_ok = 0;
            end else begin
               periph_rdata = 32'hEEEEEEEE;
               for (int l = 0; l < p; l++)
                  periph_rdata[31 - 8*l -: 8] = pmem[base + l];
            end
            proc_cnt++;
            last_proc = negcnt;
            periph_ready = 1'b1;
         end else begin
            wcnt++;
         end
      end else begin
         wcnt = 0;
      end
   endtask

   task automatic tick();
      @(negedge clk);
      negcnt++;
      model_step();
   endtask

   task automatic setup(input vec_t v);
      for (int k = 0; k < 4; k++) pmem[k] = lane(v.pinit, k);
      cur_width = v.width;
      cur_wr    = v.wr;
      wait_n    = int'(v.waitn);
      exp_next  = v.addr;
      proc_cnt  = 0;
      seq_ok = 1; repl_ok = 1; wr_ok = 1;
   endtask

   task automatic run_access(input vec_t v, input bit keep_cs,
                             output logic [31:0] rdata, output bit got_ack,
                             output int ack_at, output bit zero_ok);
      got_ack = 0; ack_at = 0; rdata = '0; zero_ok = 1;
      setup(v);
      tick();
      host_cs = 1'b1; host_addr = v.addr; host_size = v.size; host_wr = v.wr;
      port_width = v.width; host_wdata = v.wdata;
      for (int i = 0; i < 5; i++) tick();
      // R3: scramble host inputs once the capture edge has passed
      host_addr = ~v.addr; host_size = v.size + 2'd1; host_wr = ~v.wr;
      port_width = ~v.width; host_wdata = ~v.wdata;
      for (int t = 0; t < 400; t++) begin
         if (host_ack) begin
            got_ack = 1; ack_at = negcnt; rdata = host_rdata;
            break;
         end
         if (host_rdata != 32'h0) zero_ok = 0;
         tick();
      end
      tick();
      chk(!host_ack, "R8 ack lasts one cycle", {31'd0, host_ack}, 32'd0);
      if (!keep_cs) begin
         host_cs = 1'b0;
         tick();
      end
   endtask

   initial begin
      logic [31:0] rd, exp;
      bit ack_ok, zok;
      int at, strobes, acks;
      vec_t v;

      rst_n = 1'b0; host_cs = 1'b0; host_addr = '0; host_size = '0; host_wr = 1'b0;
      port_width = '0; host_wdata = '0; periph_rdata = 32'hEEEEEEEE; periph_ready = 1'b0;
      cur_width = '0; cur_wr = 1'b0; exp_next = '0; wait_addr = '0;
      for (int k = 0; k < 4; k++) pmem[k] = 8'h00;
      for (int i = 0; i < 4; i++) tick();
      chk(host_ack == 0 && periph_strobe == 0 && periph_wr == 0, "R1 reset controls",
          {29'd0, host_ack, periph_strobe, periph_wr}, 32'd0);
      chk(host_rdata == 0, "R1 reset read data", host_rdata, 32'd0);
      rst_n = 1'b1;
      tick(); tick();

      for (int i = 0; i < 14; i++) begin
         v = VEC[i];
         run_access(v, 1'b0, rd, ack_ok, at, zok);
         chk(ack_ok, $sformatf("R8 vector %0d acknowledged", i), {31'd0, ack_ok}, 32'd1);
         chk(proc_cnt == int'(v.ncyc), $sformatf("R4 vector %0d cycle count", i),
             32'(proc_cnt), 32'(v.ncyc));
         chk(seq_ok, $sformatf("R5 R11 vector %0d address sequence", i), {31'd0, seq_ok}, 32'd1);
         chk(at == last_proc + 2, $sformatf("R8 vector %0d ack timing", i), 32'(at), 32'(last_proc + 2));
         chk(zok, $sformatf("R9 vector %0d idle read data", i), {31'd0, zok}, 32'd1);
         chk(wr_ok, $sformatf("R12 vector %0d direction", i), {31'd0, wr_ok}, 32'd1);
         exp = '0;
         if (v.wr) begin
            for (int k = 0; k < 4; k++)
               exp[31 - 8*k -: 8] = lane(v.pinit, k);
            for (int k = int'(v.addr); k < int'(v.addr) + ((v.size == 0) ? 4 : int'(v.size)); k++)
               exp[31 - 8*k -: 8] = lane(v.wdata, k);
            chk({pmem[0], pmem[1], pmem[2], pmem[3]} == exp, $sformatf("R3 R6 vector %0d written bytes", i),
                {pmem[0], pmem[1], pmem[2], pmem[3]}, exp);
            chk(repl_ok, $sformatf("R6 vector %0d lane copies", i), {31'd0, repl_ok}, 32'd1);
            chk(rd == 0, $sformatf("R7 vector %0d write ack data", i), rd, 32'd0);
         end else begin
            for (int k = int'(v.addr); k < int'(v.addr) + ((v.size == 0) ? 4 : int'(v.size)); k++)
               exp[31 - 8*k -: 8] = lane(v.pinit, k);
            chk(rd == exp, $sformatf("R3 R7 vector %0d read word", i), rd, exp);
         end
      end

      // R2: chip select held high after an acknowledge starts nothing new
      run_access(VEC[0], 1'b1, rd, ack_ok, at, zok);
      strobes = 0;
      for (int i = 0; i < 20; i++) begin
         tick();
         if (periph_strobe) strobes++;
      end
      chk(strobes == 0, "R2 no restart without chip select low", 32'(strobes), 32'd0);
      host_cs = 1'b0;
      tick();

      // R10: abort in the middle of a four-cycle read
      setup(VEC[2]);
      tick();
      host_cs = 1'b1; host_addr = 2'd0; host_size = 2'b00; host_wr = 1'b0; port_width = 2'b10;
      for (int t = 0; t < 200 && proc_cnt < 2; t++) tick();
      host_cs = 1'b0;
      acks = 0; strobes = 0;
      for (int i = 0; i < 20; i++) begin
         tick();
         if (host_ack) acks++;
         if (periph_strobe) strobes++;
      end
      chk(acks == 0, "R10 no ack after mid abort", 32'(acks), 32'd0);
      chk(strobes == 0, "R10 strobe stops after abort", 32'(strobes), 32'd0);

      // R10: the next access returns only its own bytes
      run_access(VEC[5], 1'b0, rd, ack_ok, at, zok);
      chk(ack_ok && rd == 32'h000000EF, "R10 clean access after abort", rd, 32'h000000EF);

      // R10: abort before capture never reaches the peripheral
      setup(VEC[0]);
      tick();
      host_cs = 1'b1; host_addr = 2'd0; host_size = 2'b00; host_wr = 1'b0; port_width = 2'b00;
      tick(); tick();
      host_cs = 1'b0;
      acks = 0; strobes = 0;
      for (int i = 0; i < 20; i++) begin
         tick();
         if (host_ack) acks++;
         if (periph_strobe) strobes++;
      end
      chk(acks == 0 && strobes == 0, "R10 early abort silent", 32'(acks + strobes), 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule